// File: doc/BRIEF.md
# Ping-Pong Blocked Matrix Transposer

This block turns a stream of complex samples that carries a matrix in row-major order into a stream that carries the transposed matrix, Y = Xᵀ. Samples enter through a valid/ready port and leave through another valid/ready port. Matrix height, matrix width and the edge of the square tile are fixed when the block is built. All three must be powers of two, and both matrix sizes must be multiples of the tile edge.

There are two storage banks, each with one write port and one read port. They take turns. One bank fills with the incoming frame while the other bank drains the frame before it. A select register names the bank that holds the readable frame, and the roles of the two banks swap at every frame boundary. Writes go to consecutive row-major addresses. Reads are produced by a counter whose bits are re-mapped into a tiled address, so every access stays inside one square tile. When both sides stream without stalls, one sample moves per cycle through frame after frame with no idle cycles.

The output order is a blocked transpose. The outer loop runs over the tile columns of X. Inside that, it runs over the tile rows of X. Inside each tile it walks the columns of X, and for each column it walks the rows of X from top to bottom.

Top module: `mt_transposer`

## Requirements
- R1: Right after reset, out_valid is 0 and in_ready is 1.
- R2: Each output frame holds the samples of the matching input frame in this order, from outermost loop to innermost: tile column tc of X, tile row tr of X, column jj inside the tile, row ii inside the tile. The element emitted is X[tr*TILE+ii][tc*TILE+jj], with re and im passed through unchanged. Frames leave in the order they arrived.
- R3: For a frame that finds the read side idle, out_valid first rises in the cycle right after the clock edge that follows the edge which accepted the frame's last sample. It never rises before the frame has been completely written.
- R4: While one frame is being read, the block keeps in_ready high and accepts the next frame into the other bank.
- R5: If out_ready stays low, the block accepts exactly two whole frames and then holds in_ready low. It accepts input again only after a bank has been drained.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_re and out_im do not change.
- R7: When input is offered every cycle and out_ready is held high, out_valid stays high every cycle from the first output sample to the last, across frame boundaries.
- R8: No bank is written and read in the same cycle, and the readable-bank select toggles after the last read of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input sample is offered |
| in_ready | output | 1 | The block can accept the offered sample |
| in_re | input | 16 | Real part of the input sample |
| in_im | input | 16 | Imaginary part of the input sample |
| out_valid | output | 1 | An output sample is presented |
| out_ready | input | 1 | The sink takes the presented sample |
| out_re | output | 16 | Real part of the output sample |
| out_im | output | 16 | Imaginary part of the output sample |

## Verification
The hardest cycle is the one where the last write of frame n+1 and the last read of frame n fall on the same clock edge. In that cycle both bank flags change and both bank selects flip together. The bench provokes this case by streaming four frames back to back with out_ready held high, which lines the two frame boundaries up on one edge. It judges the result three ways: out_valid must show no gap, in_ready must never drop, and the scoreboard must find every sample in blocked-transpose order.

// File: rtl/mt_pkg.sv
package mt_pkg;

    localparam int CPX_W = 16;

    typedef struct packed {
        logic [CPX_W-1:0] re;
        logic [CPX_W-1:0] im;
    } cpx_t;

    localparam int CPX_BITS = $bits(cpx_t);

    // Map a linear read index onto the row-major address of a blocked transpose.
    // Index bits, inner to outer: row in tile, column in tile, tile row, tile column.
    function automatic int unsigned blk_addr(input int unsigned idx,
                                             input int unsigned tile,
                                             input int unsigned rows,
                                             input int unsigned cols);
        int unsigned ii, jj, tr, tc;
        ii = idx % tile;
        jj = (idx / tile) % tile;
        tr = (idx / (tile * tile)) % (rows / tile);
        tc = idx / (tile * rows);
        return (tr * tile + ii) * cols + tc * tile + jj;
    endfunction

endpackage

// File: rtl/mt_bank.sv
module mt_bank #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  q
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read; the value holds while re is low (used as the output stage).
    always_ff @(posedge clk) begin
        if (re) q <= mem[raddr];
    end
endmodule

// File: rtl/mt_seq.sv
module mt_seq
    import mt_pkg::*;
#(
    parameter int ROWS    = 8,
    parameter int COLS    = 8,
    parameter int TILE    = 4,
    parameter bit BLOCKED = 1'b0,
    localparam int DEPTH  = ROWS * COLS,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [AW-1:0] cnt;

    assign last = (cnt == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst)      cnt <= '0;
        else if (adv) cnt <= last ? '0 : cnt + 1'b1;
    end

    generate
        if (BLOCKED) begin : g_blocked
            assign addr = AW'(blk_addr(int'(cnt), TILE, ROWS, COLS));
        end else begin : g_linear
            assign addr = cnt;
        end
    endgenerate
endmodule

// File: rtl/mt_transposer.sv
module mt_transposer
    import mt_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int TILE   = 4,
    localparam int DEPTH = ROWS * COLS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CPX_W-1:0] in_re,
    input  logic [CPX_W-1:0] in_im,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CPX_W-1:0] out_re,
    output logic [CPX_W-1:0] out_im
);
    logic          wr_sel, rd_sel, out_bank;
    logic [1:0]    full;
    logic          wr_fire, wr_last, wr_done;
    logic          rd_fire, rd_last, rd_done;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [1:0]    bank_we, bank_re;
    cpx_t          wr_data;
    cpx_t          bank_q [2];
    cpx_t          out_data;

    assign in_ready = !full[wr_sel];
    assign wr_fire  = in_valid && in_ready;
    assign wr_done  = wr_fire && wr_last;
    assign rd_fire  = full[rd_sel] && (!out_valid || out_ready);
    assign rd_done  = rd_fire && rd_last;
    assign wr_data  = '{re: in_re, im: in_im};

    mt_seq #(.ROWS(ROWS), .COLS(COLS), .TILE(TILE), .BLOCKED(1'b0)) u_wseq (
        .clk(clk), .rst(rst), .adv(wr_fire), .addr(wr_addr), .last(wr_last)
    );

    mt_seq #(.ROWS(ROWS), .COLS(COLS), .TILE(TILE), .BLOCKED(1'b1)) u_rseq (
        .clk(clk), .rst(rst), .adv(rd_fire), .addr(rd_addr), .last(rd_last)
    );

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            assign bank_we[b] = wr_fire && (wr_sel == 1'(b));
            assign bank_re[b] = rd_fire && (rd_sel == 1'(b));
            mt_bank #(.W(CPX_BITS), .DEPTH(DEPTH)) u_mem (
                .clk(clk), .we(bank_we[b]), .waddr(wr_addr), .wdata(wr_data),
                .re(bank_re[b]), .raddr(rd_addr), .q(bank_q[b])
            );
        end
    endgenerate

    // Bank ownership: a bank is marked full by its last write and freed by its last read.
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= '0;
            wr_sel <= 1'b0;
            rd_sel <= 1'b0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (wr_done && (wr_sel == 1'(b)))      full[b] <= 1'b1;
                else if (rd_done && (rd_sel == 1'(b))) full[b] <= 1'b0;
            end
            wr_sel <= wr_sel ^ wr_done;
            rd_sel <= rd_sel ^ rd_done;
        end
    end

    // The valid flag follows the one-cycle read latency of the banks.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bank  <= 1'b0;
        end else if (rd_fire) begin
            out_valid <= 1'b1;
            out_bank  <= rd_sel;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_data = bank_q[out_bank];
    assign out_re   = out_data.re;
    assign out_im   = out_data.im;
endmodule

// File: rtl/mt_transposer_chk.sv
module mt_transposer_chk
    import mt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [CPX_W-1:0] out_re,
    input logic [CPX_W-1:0] out_im,
    input logic [1:0]       full,
    input logic             rd_sel,
    input logic             rd_fire,
    input logic             rd_last,
    input logic [1:0]       bank_we,
    input logic [1:0]       bank_re
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && in_ready));

    a_r3_valid_needs_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(|full));

    a_r5_stall_both_full: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> (full == 2'b11));

    a_r6_hold_output: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    a_r8_bank_exclusive: assert property (@(posedge clk) disable iff (rst)
        (bank_we & bank_re) == 2'b00);

    a_r8_swap_on_last_read: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_last) |=> (rd_sel != $past(rd_sel)));
endmodule

bind mt_transposer mt_transposer_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_re(out_re), .out_im(out_im), .full(full),
    .rd_sel(rd_sel), .rd_fire(rd_fire), .rd_last(rd_last),
    .bank_we(bank_we), .bank_re(bank_re)
);

// File: tb/tb_mt_transposer.sv
module tb_mt_transposer;
    localparam int R = 8;
    localparam int C = 8;
    localparam int T = 4;
    localparam int N = R * C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_re = '0, in_im = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_re, out_im;

    int checks = 0, failures = 0;
    int cyc = 0;
    int ready_mode = 0;
    logic [7:0] lfsr = 8'h5A;
    logic [31:0] exp_q[$];
    int acc_count = 0, last_acc = 0;
    bit arm_first = 0;
    int first_valid = -1;
    bit track_gap = 0;
    int gaps = 0, seen_out = 0;
    bit track_ready = 0;
    int ready_drops = 0;
    bit stall_prev = 0;
    logic [15:0] prev_re, prev_im;

    mt_transposer #(.ROWS(R), .COLS(C), .TILE(T)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
        .out_re(out_re), .out_im(out_im)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] val_re(int f, int r, int c);
        return 16'(f * 256 + r * 16 + c);
    endfunction

    // Out-ready driver
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: out_ready = lfsr[0] | lfsr[2];
        endcase
    end

    task automatic drive_sample(input logic [15:0] re);
        @(posedge clk); #2;
        in_valid = 1'b1; in_re = re; in_im = re ^ 16'hA5A5;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #2;
        end
        acc_count++;
        last_acc = cyc + 1;
    endtask

    task automatic idle_cycle();
        @(posedge clk); #2;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input int f, input bit gaps_on);
        for (int tc = 0; tc < C / T; tc++)
            for (int tr = 0; tr < R / T; tr++)
                for (int jj = 0; jj < T; jj++)
                    for (int ii = 0; ii < T; ii++) begin
                        logic [15:0] e;
                        e = val_re(f, tr * T + ii, tc * T + jj);
                        exp_q.push_back({e, e ^ 16'hA5A5});
                    end
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++) begin
                drive_sample(val_re(f, r, c));
                if (gaps_on && ((r + c) % 5 == 0)) idle_cycle();
            end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev)
                check(out_valid && out_re == prev_re && out_im == prev_im, "R6",
                      {out_re, out_im}, {prev_re, prev_im});
            if (arm_first && out_valid) begin
                first_valid = cyc;
                arm_first = 0;
            end
            if (track_gap && seen_out > 0 && seen_out < 4 * N && !out_valid) gaps++;
            if (track_ready && in_valid && !in_ready) ready_drops++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected output", {out_re, out_im}, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check({out_re, out_im} == e, "R2", {out_re, out_im}, e);
                end
                seen_out++;
            end
            stall_prev = out_valid && !out_ready;
            prev_re = out_re;
            prev_im = out_im;
        end
    end

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(!out_valid, "R2 no extra output", out_valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);

        // R3: one frame onto an idle read side
        arm_first = 1;
        send_frame(0, 0);
        idle_cycle();
        while (arm_first) @(negedge clk);
        check(first_valid == last_acc + 1, "R3 first valid cycle", first_valid, last_acc + 1);
        drain();

        // R4 / R7: four frames back to back, sink always ready
        seen_out = 0; gaps = 0; ready_drops = 0;
        track_gap = 1; track_ready = 1;
        for (int f = 1; f <= 4; f++) send_frame(f, 0);
        idle_cycle();
        drain();
        track_gap = 0; track_ready = 0;
        check(gaps == 0, "R7 output gaps", gaps, 0);
        check(ready_drops == 0, "R4 in_ready drops", ready_drops, 0);
        check(seen_out == 4 * N, "R7 output count", seen_out, 4 * N);

        // R5 / R6: sink stalled, three frames offered
        ready_mode = 1;
        acc_count = 0;
        fork
            begin
                for (int f = 5; f <= 7; f++) send_frame(f, 0);
                idle_cycle();
            end
        join_none
        repeat (3 * N + 20) @(negedge clk);
        check(acc_count == 2 * N, "R5 accepted while stalled", acc_count, 2 * N);
        check(in_ready == 1'b0, "R5 in_ready low", in_ready, 0);
        check(out_valid == 1'b1, "R6 valid held", out_valid, 1);
        ready_mode = 0;
        wait fork;
        drain();
        check(acc_count == 3 * N, "R5 resumed", acc_count, 3 * N);

        // R2 / R6: irregular input and random back-pressure
        ready_mode = 2;
        for (int f = 8; f <= 10; f++) send_frame(f, 1);
        idle_cycle();
        drain();
        ready_mode = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule